// File: doc/BRIEF.md
# Three-bit-group Ling pseudo-carry adder

This block adds two unsigned or two's-complement operands together with an incoming carry. It produces the sum, the carry out of the top bit and a signed overflow flag. The carry network does not pass ordinary carries between groups. Instead it forms a pseudo-carry once every three bit positions, using generate (both bits set) and transmit (either bit set) terms. Each real carry is then recovered with a single AND against the transmit term of the bit just below it. Inside a group, the two remaining carries ripple from the group's real carry-in, and every sum bit is the half-sum XOR its carry.

The operand width is a parameter and must be a multiple of three. A second parameter picks the output stage. In the default combinational form the block is pure logic, and the clock and reset are used only by the embedded checks. In the registered form the three results are captured in one flop stage with an asynchronous active-low reset.

Top module: `ling_adder`

## Requirements
- R1: `sum` equals (`a` + `b` + `cin`) modulo 2^W for every operand pattern.
- R2: `cout` equals bit W of the (W+1)-bit result of `a` + `b` + `cin`, which is the real carry leaving the most significant bit position.
- R3: `ovf` is 1 exactly when `a[W-1]` equals `b[W-1]` and `sum[W-1]` differs from them. This is equal to `cout` XOR the carry entering bit W-1.
- R4: The real carry entering every group boundary (bit positions 3, 6, …) equals bit k of `a[k-1:0]` + `b[k-1:0]` + `cin`. Sums whose carries cross one or more boundaries (for example 0x007+0x001 = 0x008, 0x03F+0x001 = 0x040) are therefore exact.
- R5: With `a` all ones, `b` zero and `cin` = 1, the carry travels through every group: `sum` is all zeros and `cout` is 1.
- R6: With REG_OUT = 1, `sum`, `cout` and `ovf` show the result of the inputs present at the previous rising clock edge. They hold that value until the next edge. While `rst_n` is low, all three read 0.
- R7: With REG_OUT = 0, the outputs follow the inputs without any clock edge, whatever the state of `rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage and the checks |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Incoming carry |
| sum | output | W | Sum modulo 2^W |
| cout | output | 1 | Carry out of the most significant bit |
| ovf | output | 1 | Two's-complement overflow |

## Verification
The bench builds two copies of the block. The first has W = 6 with REG_OUT = 0, which makes all 8192 combinations of operands and carry-in reachable. That covers every pattern of generate, transmit and pseudo-carry across the single group boundary. The second has W = 12 with REG_OUT = 1, which brings in four groups, three boundaries, and the reset and one-cycle latency of the output stage. It is driven with a table of hand-computed vectors for sign extremes and long propagate runs, followed by random operands compared against plain integer addition.

// File: rtl/ling_pkg.sv
package ling_pkg;
  // Per-bit terms feeding the Ling network.
  typedef struct packed {
    logic gen;   // both operand bits set
    logic xmit;  // either operand bit set
    logic hsum;  // operand bits differ
  } bit_term_t;

  localparam int GROUP_BITS = 3;
endpackage

// File: rtl/ling_terms.sv
module ling_terms
  import ling_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  output bit_term_t [W-1:0] terms
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign terms[i].gen  = op_a[i] & op_b[i];
    assign terms[i].xmit = op_a[i] | op_b[i];
    assign terms[i].hsum = op_a[i] ^ op_b[i];
  end
endmodule

// File: rtl/ling_group.sv
module ling_group
  import ling_pkg::*;
(
  input  bit_term_t [2:0] trm,      // terms of the three bits, [0] lowest
  input  logic            xmit_low, // transmit of the bit below the group (1 for group 0)
  input  logic            h_in,     // pseudo-carry entering the group
  output logic            c_in,     // real carry entering the group
  output logic            c_top,    // real carry entering the group's top bit
  output logic            h_out,    // pseudo-carry for the next group
  output logic            c_out,    // real carry leaving the group
  output logic [2:0]      s
);
  logic c_mid;

  always_comb begin
    // real carry from pseudo-carry: a single AND with the transmit below
    c_in  = h_in & xmit_low;
    // inside the group the carries ripple from the real carry-in
    c_mid = trm[0].gen | (trm[0].xmit & c_in);
    c_top = trm[1].gen | (trm[1].xmit & c_mid);
    // next pseudo-carry; the top transmit is factored out of every term
    h_out = trm[2].gen | trm[1].gen | (trm[1].xmit & trm[0].gen)
          | (trm[1].xmit & trm[0].xmit & xmit_low & h_in);
    c_out = h_out & trm[2].xmit;
    s     = {trm[2].hsum, trm[1].hsum, trm[0].hsum} ^ {c_top, c_mid, c_in};
  end
endmodule

// File: rtl/ling_adder.sv
module ling_adder
  import ling_pkg::*;
#(
  parameter int W       = 12,
  parameter bit REG_OUT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int NG = W / GROUP_BITS;

  bit_term_t [W-1:0] terms;
  logic [NG:0]       h;
  logic [NG-1:0]     grp_cin, grp_ctop, grp_cout;
  logic [W-1:0]      sum_c;
  logic              cout_c, ovf_c;

  ling_terms #(.W(W)) u_terms (.op_a(a), .op_b(b), .terms(terms));

  assign h[0] = cin;

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    logic xlow;
    if (gi == 0) begin : g_first
      assign xlow = 1'b1;
    end else begin : g_rest
      assign xlow = terms[GROUP_BITS*gi-1].xmit;
    end
    ling_group u_grp (
      .trm      (terms[GROUP_BITS*gi +: GROUP_BITS]),
      .xmit_low (xlow),
      .h_in     (h[gi]),
      .c_in     (grp_cin[gi]),
      .c_top    (grp_ctop[gi]),
      .h_out    (h[gi+1]),
      .c_out    (grp_cout[gi]),
      .s        (sum_c[GROUP_BITS*gi +: GROUP_BITS])
    );
  end

  assign cout_c = grp_cout[NG-1];
  assign ovf_c  = cout_c ^ grp_ctop[NG-1];

  // arithmetic reference used only by the checks
  logic [W:0] ref_add;
  assign ref_add = {1'b0, a} + {1'b0, b} + (W+1)'(cin);

  // R4: real carry at each boundary matches the arithmetic carry of the lower part
  for (genvar k = 1; k < NG; k++) begin : g_bchk
    localparam int LB = GROUP_BITS * k;
    logic [LB:0] low_ref;
    assign low_ref = {1'b0, a[LB-1:0]} + {1'b0, b[LB-1:0]} + (LB+1)'(cin);
    // R4
    boundary_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_cin[k] == low_ref[LB]);
  end

  if (REG_OUT) begin : g_reg
    logic [W-1:0] sum_d, sum_q;
    logic         cout_d, cout_q, ovf_d, ovf_q;

    always_comb begin
      sum_d  = sum_c;
      cout_d = cout_c;
      ovf_d  = ovf_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q  <= '0;
        cout_q <= 1'b0;
        ovf_q  <= 1'b0;
      end else begin
        sum_q  <= sum_d;
        cout_q <= cout_d;
        ovf_q  <= ovf_d;
      end
    end

    assign sum  = sum_q;
    assign cout = cout_q;
    assign ovf  = ovf_q;

    // R6 R1
    reg_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> sum == $past(ref_add[W-1:0]));
    // R6 R2
    reg_cout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> cout == $past(ref_add[W]));
    // R6 R3
    reg_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ovf == $past((a[W-1] == b[W-1]) && (ref_add[W-1] != a[W-1])));
  end else begin : g_comb
    assign sum  = sum_c;
    assign cout = cout_c;
    assign ovf  = ovf_c;

    // R1
    comb_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sum == ref_add[W-1:0]);
    // R2
    comb_cout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cout == ref_add[W]);
    // R3
    comb_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf == ((a[W-1] == b[W-1]) && (sum[W-1] != a[W-1])));
  end
endmodule

// File: tb/ling_adder_test.sv
module ling_adder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] a, b;
  logic        cin;
  logic [11:0] sum;
  logic        cout, ovf;
  logic [5:0]  a6, b6;
  logic        cin6;
  logic [5:0]  sum6;
  logic        cout6, ovf6;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ling_adder #(.W(12), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin),
    .sum(sum), .cout(cout), .ovf(ovf));

  ling_adder #(.W(6), .REG_OUT(1'b0)) uut_small (
    .clk(clk), .rst_n(rst_n), .a(a6), .b(b6), .cin(cin6),
    .sum(sum6), .cout(cout6), .ovf(ovf6));

  // {a, b, cin, sum, cout, ovf}
  localparam logic [38:0] VEC [11] = '{
    {12'h000, 12'h000, 1'b0, 12'h000, 1'b0, 1'b0},
    {12'hFFF, 12'h001, 1'b0, 12'h000, 1'b1, 1'b0},
    {12'hFFF, 12'h000, 1'b1, 12'h000, 1'b1, 1'b0},  // R5 full propagate
    {12'h7FF, 12'h001, 1'b0, 12'h800, 1'b0, 1'b1},
    {12'h800, 12'h800, 1'b0, 12'h000, 1'b1, 1'b1},
    {12'h800, 12'hFFF, 1'b0, 12'h7FF, 1'b1, 1'b1},
    {12'h123, 12'h456, 1'b1, 12'h57A, 1'b0, 1'b0},
    {12'hABC, 12'hDEF, 1'b0, 12'h8AB, 1'b1, 1'b0},
    {12'h555, 12'hAAA, 1'b1, 12'h000, 1'b1, 1'b0},
    {12'h007, 12'h001, 1'b0, 12'h008, 1'b0, 1'b0},  // R4 one boundary
    {12'h03F, 12'h001, 1'b0, 12'h040, 1'b0, 1'b0}   // R4 two boundaries
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive12(input logic [11:0] va, input logic [11:0] vb, input logic vc);
    @(negedge clk);
    a = va; b = vb; cin = vc;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a = 12'hFFF; b = 12'h123; cin = 1'b1;
    a6 = 6'h3F; b6 = 6'h01; cin6 = 1'b0;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 reset sum", 32'(sum), 32'h0);
    chk("R6 reset cout", 32'(cout), 32'h0);
    chk("R6 reset ovf", 32'(ovf), 32'h0);
    // R7 combinational copy answers during reset
    #1;
    chk("R7 sum6 in reset", 32'(sum6), 32'h00);
    chk("R7 cout6 in reset", 32'(cout6), 32'h1);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk on the registered 12-bit copy
    for (int i = 0; i < 11; i++) begin
      drive12(VEC[i][38:27], VEC[i][26:15], VEC[i][14]);
      @(negedge clk);
      chk("R1 table sum", 32'(sum), 32'(VEC[i][13:2]));
      chk("R2 table cout", 32'(cout), 32'(VEC[i][1]));
      chk("R3 table ovf", 32'(ovf), 32'(VEC[i][0]));
    end

    // R6 latency: new inputs do not show before the next edge
    drive12(12'h001, 12'h002, 1'b0);
    @(negedge clk);
    a = 12'h100; b = 12'h200; cin = 1'b1;
    #1;
    chk("R6 hold before edge", 32'(sum), 32'h003);
    @(negedge clk);
    chk("R6 after edge", 32'(sum), 32'h301);

    // R6 reset mid-run clears outputs at once
    drive12(12'hFFF, 12'hFFF, 1'b1);
    @(negedge clk);
    chk("R6 pre-reset sum", 32'(sum), 32'hFFF);
    rst_n = 1'b0;
    #1;
    chk("R6 async clear sum", 32'(sum), 32'h0);
    chk("R6 async clear cout", 32'(cout), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed on the 6-bit copy
    a6 = 6'h3F; b6 = 6'h00; cin6 = 1'b1; #1;
    chk("R5 sum6", 32'(sum6), 32'h00);
    chk("R5 cout6", 32'(cout6), 32'h1);
    a6 = 6'h07; b6 = 6'h01; cin6 = 1'b0; #1;
    chk("R4 sum6 boundary", 32'(sum6), 32'h08);

    // exhaustive 6-bit
    for (int va = 0; va < 64; va++) begin
      for (int vb = 0; vb < 64; vb++) begin
        for (int vc = 0; vc < 2; vc++) begin
          logic [6:0] r;
          logic       ov;
          a6 = 6'(va); b6 = 6'(vb); cin6 = 1'(vc);
          #1;
          r  = 7'(va) + 7'(vb) + 7'(vc);
          ov = (a6[5] == b6[5]) && (r[5] != a6[5]);
          chk("R1 R2 R3 exhaustive6", {24'h0, ovf6, cout6, sum6}, {24'h0, ov, r[6], r[5:0]});
        end
      end
    end

    // random 12-bit through the register stage
    for (int n = 0; n < 400; n++) begin
      logic [11:0] ra, rb;
      logic        rc, ov;
      logic [12:0] r;
      ra = 12'($urandom); rb = 12'($urandom); rc = 1'($urandom);
      drive12(ra, rb, rc);
      @(negedge clk);
      r  = {1'b0, ra} + {1'b0, rb} + 13'(rc);
      ov = (ra[11] == rb[11]) && (r[11] != ra[11]);
      chk("R1 R2 R3 random12", {18'h0, ov, r[12], r[11:0]}, {18'h0, ovf, cout, sum});
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule